// File: doc/BRIEF.md
# Battery Profile Slot Selector

This block decides which of two stored battery-model slots becomes active once a pack has been inserted and its impedance measured. A measurement arrives as a one-cycle strobe carrying an impedance word. Each slot keeps a reference impedance and a valid bit. A slot counts as a match when it is valid and the measurement lies within a programmable tolerance of its reference. A matching slot is selected in the next cycle.

When neither slot matches, the pack is treated as one never seen before. A default profile is copied word by word from an external source into the slot used least recently. The copy is driven through write strobes, a slot index and a word address. When the copy ends, that slot is selected, flagged as a new pack, and its reference takes the measured impedance. A single age bit records the most recently selected slot.

Top module: `pack_slot_select`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, sel_stb_o, sel_slot_o, new_pack_o, busy_o, done_o and copy_we_o are 0, the tolerance is 0 and both slots are invalid.
- R2: A slot matches when it is valid and the absolute difference between meas_imp_i and its reference is at most the tolerance. The bound is inclusive, and a difference of tolerance plus one does not match.
- R3: When a measurement is accepted and a slot matches, sel_stb_o is 1 in the following cycle, with sel_slot_o giving the slot (0 or 1) and new_pack_o at 0. If both slots match, slot 0 is chosen.
- R4: When an accepted measurement matches no slot, the victim is the slot not most recently selected, and busy_o rises in the following cycle. The age bit resets to 1, so slot 0 is the first victim.
- R5: A copy takes PROF_LEN consecutive cycles with copy_we_o at 1 and copy_addr_o running from 0 to PROF_LEN-1. def_addr_o equals copy_addr_o, copy_data_o carries def_data_i in the same cycle, and copy_slot_o holds the victim.
- R6: In the cycle after the last copy write, done_o and sel_stb_o are 1, busy_o is 0, sel_slot_o is the victim and new_pack_o is 1. The victim's reference becomes the measured impedance and the slot becomes valid, and this holds for a measurement strobed in that same cycle.
- R7: Every selection, whether a hit or a finished copy, makes the selected slot the most recent, and this decides the next victim.
- R8: A measurement strobed while busy_o is 1 is ignored. It does not alter the running copy, the victim or any later selection.
- R9: A cycle with tol_we_i at 1 loads tol_i as the tolerance. That new value applies to measurements from the next cycle, and a measurement in the same cycle uses the old tolerance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tol_we_i | input | 1 | Tolerance load enable |
| tol_i | input | IMP_W | Tolerance value |
| meas_valid_i | input | 1 | Measurement strobe |
| meas_imp_i | input | IMP_W | Measured impedance |
| def_addr_o | output | AW | Default profile word address |
| def_data_i | input | DATA_W | Default profile word |
| copy_we_o | output | 1 | Profile word write strobe |
| copy_slot_o | output | 1 | Slot being written |
| copy_addr_o | output | AW | Word address in the slot |
| copy_data_o | output | DATA_W | Word written |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | Copy finished, one-cycle pulse |
| sel_stb_o | output | 1 | Selection made, one-cycle pulse |
| sel_slot_o | output | 1 | Selected slot |
| new_pack_o | output | 1 | Last selection was a new pack |

## Verification
The completion of a copy and a new measurement can fall in the same cycle. The copy's end updates the victim's reference and the age bit, while the measurement is compared against both slots. The bench waits for done_o and strobes a measurement close to the just-copied impedance in that very cycle. The reference model then expects a hit on the fresh slot in the next cycle. A strobe on the last busy cycle and a tolerance write made together with a measurement are also driven, and each is judged against the model's expected outputs.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int NSLOT = 2;
  typedef logic slot_t;
endpackage

// File: rtl/pss_imp_match.sv
module pss_imp_match #(
  parameter int IMP_W = 16
) (
  input  logic             valid_i,
  input  logic [IMP_W-1:0] ref_i,
  input  logic [IMP_W-1:0] meas_i,
  input  logic [IMP_W-1:0] tol_i,
  output logic             hit_o
);
  logic [IMP_W-1:0] diff;

  always_comb begin
    if (meas_i >= ref_i) diff = meas_i - ref_i;
    else                 diff = ref_i - meas_i;
    hit_o = valid_i && (diff <= tol_i);
  end
endmodule

// File: rtl/pss_slot_bank.sv
module pss_slot_bank
  import pss_pkg::*;
#(
  parameter int IMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  slot_t            wr_slot_i,
  input  logic [IMP_W-1:0] wr_imp_i,
  output logic [IMP_W-1:0] ref_o [NSLOT],
  output logic [NSLOT-1:0] valid_o
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ref_o[s]   <= '0;
        valid_o[s] <= 1'b0;
      end else if (wr_i && (int'(wr_slot_i) == s)) begin
        ref_o[s]   <= wr_imp_i;
        valid_o[s] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pss_copy_seq.sv
module pss_copy_seq #(
  parameter int PROF_LEN = 8,
  localparam int AW = (PROF_LEN > 1) ? $clog2(PROF_LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic [AW-1:0] addr_o,
  output logic          last_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = AW'(PROF_LEN - 1);

  assign last_o = busy_o && (addr_o == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      addr_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last_o;
      if (last_o) begin
        busy_o <= 1'b0;
        addr_o <= '0;
      end else if (busy_o) begin
        addr_o <= addr_o + 1'b1;
      end else if (start_i) begin
        busy_o <= 1'b1;
        addr_o <= '0;
      end
    end
  end
endmodule

// File: rtl/pack_slot_select.sv
module pack_slot_select
  import pss_pkg::*;
#(
  parameter int IMP_W    = 16,
  parameter int DATA_W   = 16,
  parameter int PROF_LEN = 8,
  localparam int AW = (PROF_LEN > 1) ? $clog2(PROF_LEN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tol_we_i,
  input  logic [IMP_W-1:0]  tol_i,
  input  logic              meas_valid_i,
  input  logic [IMP_W-1:0]  meas_imp_i,
  output logic [AW-1:0]     def_addr_o,
  input  logic [DATA_W-1:0] def_data_i,
  output logic              copy_we_o,
  output logic              copy_slot_o,
  output logic [AW-1:0]     copy_addr_o,
  output logic [DATA_W-1:0] copy_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sel_stb_o,
  output logic              sel_slot_o,
  output logic              new_pack_o
);
  logic [IMP_W-1:0] tol_q, pend_q;
  logic [IMP_W-1:0] ref_w [NSLOT];
  logic [NSLOT-1:0] valid_w, hit_w;
  slot_t            mru_q, victim_q;
  logic             busy_w, last_w, accept, miss;
  logic [AW-1:0]    addr_w;

  assign accept = meas_valid_i && !busy_w;
  assign miss   = accept && (hit_w == '0);

  for (genvar s = 0; s < NSLOT; s++) begin : g_match
    pss_imp_match #(.IMP_W(IMP_W)) u_match (
      .valid_i(valid_w[s]),
      .ref_i  (ref_w[s]),
      .meas_i (meas_imp_i),
      .tol_i  (tol_q),
      .hit_o  (hit_w[s])
    );
  end

  pss_slot_bank #(.IMP_W(IMP_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (last_w),
    .wr_slot_i(victim_q),
    .wr_imp_i (pend_q),
    .ref_o    (ref_w),
    .valid_o  (valid_w)
  );

  pss_copy_seq #(.PROF_LEN(PROF_LEN)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(miss),
    .busy_o (busy_w),
    .addr_o (addr_w),
    .last_o (last_w),
    .done_o (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tol_q      <= '0;
      pend_q     <= '0;
      mru_q      <= 1'b1;  // first victim is slot 0
      victim_q   <= 1'b0;
      sel_stb_o  <= 1'b0;
      sel_slot_o <= 1'b0;
      new_pack_o <= 1'b0;
    end else begin
      sel_stb_o <= 1'b0;
      if (tol_we_i) tol_q <= tol_i;
      if (last_w) begin
        sel_stb_o  <= 1'b1;
        sel_slot_o <= victim_q;
        new_pack_o <= 1'b1;
        mru_q      <= victim_q;
      end else if (accept) begin
        if (hit_w != '0) begin
          sel_stb_o  <= 1'b1;
          sel_slot_o <= !hit_w[0];  // slot 0 has priority
          new_pack_o <= 1'b0;
          mru_q      <= !hit_w[0];
        end else begin
          victim_q <= !mru_q;
          pend_q   <= meas_imp_i;
        end
      end
    end
  end

  assign busy_o      = busy_w;
  assign copy_we_o   = busy_w;
  assign copy_slot_o = victim_q;
  assign copy_addr_o = addr_w;
  assign def_addr_o  = addr_w;
  assign copy_data_o = def_data_i;
endmodule

// File: rtl/pack_slot_select_chk.sv
module pack_slot_select_chk #(
  parameter int AW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          meas_valid_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          sel_stb_o,
  input logic          new_pack_o,
  input logic          copy_slot_o,
  input logic [AW-1:0] copy_addr_o
);
  assert_busy_no_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sel_stb_o);

  assert_done_selects_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (sel_stb_o && new_pack_o && !busy_o && $past(busy_o)));

  assert_start_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (copy_addr_o == '0));

  assert_addr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (copy_addr_o == $past(copy_addr_o) + 1'b1));

  assert_slot_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(copy_slot_o));

  assert_hit_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_stb_o && !new_pack_o) |-> ($past(meas_valid_i) && !$past(busy_o)));
endmodule

bind pack_slot_select pack_slot_select_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .meas_valid_i(meas_valid_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .sel_stb_o   (sel_stb_o),
  .new_pack_o  (new_pack_o),
  .copy_slot_o (copy_slot_o),
  .copy_addr_o (copy_addr_o)
);

// File: tb/pack_slot_select_bench.sv
`timescale 1ns/1ps
module pack_slot_select_bench;
  localparam int IMP_W = 16, DATA_W = 16, PROF_LEN = 8, AW = 3;

  logic clk_i = 0, rst_ni = 0;
  logic tol_we_i = 0, meas_valid_i = 0;
  logic [IMP_W-1:0] tol_i = 0, meas_imp_i = 0;
  logic [AW-1:0] def_addr_o, copy_addr_o;
  logic [DATA_W-1:0] def_data_i, copy_data_o;
  logic copy_we_o, copy_slot_o, busy_o, done_o, sel_stb_o, sel_slot_o, new_pack_o;

  always #2.5 clk_i = ~clk_i;

  function automatic int def_word(int a);
    return (16'h5A00 ^ (a * 29)) & 16'hFFFF;
  endfunction
  assign def_data_i = DATA_W'(def_word(int'(def_addr_o)));

  pack_slot_select #(.IMP_W(IMP_W), .DATA_W(DATA_W), .PROF_LEN(PROF_LEN)) u_pack_slot_select (.*);

  int checks = 0, failures = 0, cyc = 0;
  string phase = "R1";

  // behavioural reference model
  int m_ref[2], m_val[2], m_mru, m_tol, m_busy, m_cnt, m_vic, m_pend;
  int e_stb, e_slot, e_new, e_done;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ref = '{0, 0}; m_val = '{0, 0}; m_mru = 1; m_tol = 0;
      m_busy = 0; m_cnt = 0; m_vic = 0; m_pend = 0;
      e_stb = 0; e_slot = 0; e_new = 0; e_done = 0;
    end else begin
      int nt, d0, d1, h0, h1;
      nt = tol_we_i ? int'(tol_i) : m_tol;
      e_stb = 0; e_done = 0;
      if (m_busy != 0) begin
        if (m_cnt == PROF_LEN - 1) begin
          m_busy = 0; m_cnt = 0; e_done = 1; e_stb = 1; e_slot = m_vic; e_new = 1;
          m_ref[m_vic] = m_pend; m_val[m_vic] = 1; m_mru = m_vic;
        end else m_cnt++;
      end else if (meas_valid_i) begin
        d0 = int'(meas_imp_i) - m_ref[0]; if (d0 < 0) d0 = -d0;
        d1 = int'(meas_imp_i) - m_ref[1]; if (d1 < 0) d1 = -d1;
        h0 = (m_val[0] != 0) && (d0 <= m_tol);
        h1 = (m_val[1] != 0) && (d1 <= m_tol);
        if (h0 != 0)      begin e_stb = 1; e_slot = 0; e_new = 0; m_mru = 0; end
        else if (h1 != 0) begin e_stb = 1; e_slot = 1; e_new = 0; m_mru = 1; end
        else begin m_busy = 1; m_cnt = 0; m_vic = 1 - m_mru; m_pend = int'(meas_imp_i); end
      end
      m_tol = nt;
    end
  end

  task automatic chk(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s/%s act=%0d exp=%0d t=%0t", tag, phase, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    string ts, tc, td;
    ts = rst_ni ? "R3" : "R1";
    tc = rst_ni ? "R5" : "R1";
    td = rst_ni ? "R6" : "R1";
    chk(ts, "sel_stb", int'(sel_stb_o), e_stb);
    chk(ts, "sel_slot", int'(sel_slot_o), e_slot);
    chk(ts, "new_pack", int'(new_pack_o), e_new);
    chk(td, "done", int'(done_o), e_done);
    chk(tc, "busy", int'(busy_o), m_busy);
    chk(tc, "copy_we", int'(copy_we_o), m_busy);
    if (m_busy != 0) begin
      chk("R5", "copy_addr", int'(copy_addr_o), m_cnt);
      chk("R5", "def_addr", int'(def_addr_o), m_cnt);
      chk("R5", "copy_data", int'(copy_data_o), def_word(m_cnt));
      chk("R4", "copy_slot", int'(copy_slot_o), m_vic);
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 20000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic meas(int v);
    @(negedge clk_i); meas_valid_i = 1; meas_imp_i = IMP_W'(v);
    @(negedge clk_i); meas_valid_i = 0;
  endtask

  task automatic set_tol(int v);
    @(negedge clk_i); tol_we_i = 1; tol_i = IMP_W'(v);
    @(negedge clk_i); tol_we_i = 0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    phase = "R9"; set_tol(10);
    phase = "R4"; meas(1000); wait_done();          // first victim slot 0
    phase = "R6"; meas_valid_i = 1; meas_imp_i = 1005; // strobe in the done cycle
    @(negedge clk_i); meas_valid_i = 0;
    phase = "R4"; meas(2000);                        // LRU victim slot 1
    phase = "R8"; meas(1000);                        // ignored mid-copy
    while (!(busy_o && copy_addr_o == AW'(PROF_LEN - 1))) @(negedge clk_i);
    meas_valid_i = 1; meas_imp_i = 1000;             // ignored on last write
    @(negedge clk_i); meas_valid_i = 0;
    wait_done();
    phase = "R2"; meas(1010); meas(990); meas(1011); wait_done();
    phase = "R7"; meas(1011); meas(5000); wait_done();
    meas(1000); wait_done();
    phase = "R3"; set_tol(4000); meas(3000);         // both match, slot 0 wins
    phase = "R9";
    @(negedge clk_i); tol_we_i = 1; tol_i = 0; meas_valid_i = 1; meas_imp_i = 3000;
    @(negedge clk_i); tol_we_i = 0; meas_valid_i = 0;
    meas(3000); wait_done();
    phase = "R2"; meas(16'hFFFF); wait_done(); meas(0); wait_done();
    repeat (4) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule